// File: doc/BRIEF.md
# Variable-Width SPI Register Slave

This block is a SPI slave in clock mode 0 that gives a host access to a small register file. Its registers are 8, 16 or 24 bits wide. Chip select low frames one transaction. The transaction opens with a header byte that carries a direction bit and a 7-bit address. A data field follows, and its length is the width of the addressed register, so frames last 16, 24 or 32 SCLK cycles. The serial inputs are oversampled by the system clock through two-stage synchronizers.

The serial output pin has two jobs. While no read data is being returned, it carries an active-low interrupt flag. That flag is the OR of the status inputs masked by an interrupt-enable register. On a read the pin switches to register data once the header byte is done. A write is stored only on the rising edge that carries its last data bit, so raising chip select earlier cancels it. A completed write issued while the conversion engine reports busy sends that engine a one-clock abort pulse. Until the ready input signals that wakeup has finished, the block stores nothing and returns no data.

Top module: `spi_regslave`

## Requirements
- R1: DIN is sampled on SCLK rising edges. DOUT changes only after SCLK falling edges and holds its value through each SCLK high phase.
- R2: Header bit 7 set to 1 means read and 0 means write. Bits 6:0 are the address, and all fields are sent MSB first. Address map: 0x00 cfg (8 bits), 0x01 mux (8 bits), 0x02 seq (16 bits), 0x03 interrupt enable (24 bits), 0x04 status (24 bits, read-only, returns the status input), 0x05 coef (24 bits). Any other address is 8 bits wide, reads as 0 and stores nothing.
- R3: A write to a register of width W is stored on SCLK rising edge 8+W. The stored value is the W data bits sent MSB first.
- R4: If chip select rises before rising edge 8+W, the register keeps its old value and no abort pulse is produced.
- R5: The interrupt flag is low when (status AND interrupt enable) is nonzero and high otherwise. DOUT carries this flag while chip select is high and during the header byte.
- R6: On a read, the MSB of the register appears on DOUT after the SCLK falling edge that follows rising edge 8. Each later falling edge presents the next bit. A read changes no register and never pulses abort.
- R7: A completed write while busy is high produces exactly one clock cycle of abort high. A completed write while busy is low produces none.
- R8: While ready is low, writes store nothing and pulse no abort. Reads keep DOUT on the interrupt flag for the whole frame.
- R9: SCLK edges after rising edge 8+W, up to the rise of chip select, have no effect.
- R10: After reset every register is 0, abort is low, and DOUT is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles low |
| csb | input | 1 | Active-low chip select |
| din | input | 1 | Serial data in |
| dout_intb | output | 1 | Serial data out, or the active-low interrupt flag |
| ready | input | 1 | High once wakeup is done |
| busy | input | 1 | Conversion or calibration in progress |
| abort | output | 1 | One-cycle pulse that cancels the running conversion |
| status | input | 24 | Status bits from the conversion engine |
| cfg | output | 8 | cfg register |
| mux | output | 8 | mux register |
| seq | output | 16 | seq register |
| irq_en | output | 24 | Interrupt enable register |
| coef | output | 24 | coef register |

## Verification
The assertions check four things on every cycle. An abort pulse is one cycle long and requires busy and ready, and it never follows a read. Registers hold still unless chip select was low. Read data starts only after the header byte, and the bit counter never passes the frame length. The bench scenarios cover the rest. They check the stored value for each register width, MSB-first read data and the interrupt flag on the pin. They also check cancellation by an early chip-select rise, clocks beyond the frame being ignored, and gating by the ready input.

// File: rtl/spi_regslave.sv
module spi_regslave (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        csb,
  input  logic        din,
  output logic        dout_intb,
  input  logic        ready,
  input  logic        busy,
  output logic        abort,
  input  logic [23:0] status,
  output logic [7:0]  cfg,
  output logic [7:0]  mux,
  output logic [15:0] seq,
  output logic [23:0] irq_en,
  output logic [23:0] coef
);

  logic [1:0]  sclk_q, csb_q, din_q;
  logic        sclk_d;
  logic [5:0]  cnt;
  logic [22:0] in_sr;
  logic [7:0]  hdr;
  logic [23:0] out_sr;
  logic        rd_pend, rd_act;

  wire sclk_s = sclk_q[1];
  wire csb_s  = csb_q[1];
  wire din_s  = din_q[1];
  wire rise   = !csb_s && sclk_s && !sclk_d;
  wire fall   = !csb_s && !sclk_s && sclk_d;

  function automatic logic [5:0] frame_len(input logic [6:0] a);
    case (a)
      7'h02:               frame_len = 6'd24;
      7'h03, 7'h04, 7'h05: frame_len = 6'd32;
      default:             frame_len = 6'd16;
    endcase
  endfunction

  wire [7:0]  nh    = {in_sr[6:0], din_s};
  wire [23:0] wdata = {in_sr, din_s};
  wire [5:0]  flen  = frame_len(hdr[6:0]);
  wire        live  = (cnt < 6'd8) || (cnt < flen);
  wire        commit = rise && cnt >= 6'd8 && (cnt + 6'd1) == flen && !hdr[7] && ready;
  wire        irq   = |(status & irq_en);

  logic [23:0] rdata;
  always_comb begin
    case (nh[6:0])
      7'h00:   rdata = {cfg, 16'h0};
      7'h01:   rdata = {mux, 16'h0};
      7'h02:   rdata = {seq, 8'h0};
      7'h03:   rdata = irq_en;
      7'h04:   rdata = status;
      7'h05:   rdata = coef;
      default: rdata = 24'h0;
    endcase
  end

  assign dout_intb = rd_act ? out_sr[23] : !irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 2'b00;
      csb_q  <= 2'b11;
      din_q  <= 2'b00;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[0], sclk};
      csb_q  <= {csb_q[0], csb};
      din_q  <= {din_q[0], din};
      sclk_d <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      in_sr   <= '0;
      hdr     <= '0;
      out_sr  <= '0;
      rd_pend <= 1'b0;
      rd_act  <= 1'b0;
    end else if (csb_s) begin
      cnt     <= '0;
      out_sr  <= '0;
      rd_pend <= 1'b0;
      rd_act  <= 1'b0;
    end else begin
      if (rise && live) begin
        cnt   <= cnt + 6'd1;
        in_sr <= wdata[22:0];
        if (cnt == 6'd7) begin
          hdr <= nh;
          if (nh[7] && ready) begin
            out_sr  <= rdata;
            rd_pend <= 1'b1;
          end
        end
      end
      if (fall && rd_pend) begin
        if (rd_act) out_sr <= out_sr << 1;
        else        rd_act <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort  <= 1'b0;
      cfg    <= '0;
      mux    <= '0;
      seq    <= '0;
      irq_en <= '0;
      coef   <= '0;
    end else begin
      abort <= commit && busy;
      if (commit) begin
        case (hdr[6:0])
          7'h00:   cfg    <= wdata[7:0];
          7'h01:   mux    <= wdata[7:0];
          7'h02:   seq    <= wdata[15:0];
          7'h03:   irq_en <= wdata;
          7'h05:   coef   <= wdata;
          default: ;
        endcase
      end
    end
  end

  AST_ABORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(busy)); // R7
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort); // R7
  AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ready) |-> !abort); // R8
  AST_NO_READ_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !hdr[7]); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csb_s) |-> ($stable(cfg) && $stable(seq) && $stable(coef))); // R4
  AST_DATA_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_act) |-> cnt == 6'd8); // R6
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 6'd8) |-> cnt <= flen); // R9

endmodule

// File: tb/tb_spi_regslave.sv
`timescale 1ns/1ps
module tb_spi_regslave;
  localparam int HP = 8;

  logic clk = 0, rst_n = 0, sclk = 0, csb = 1, din = 0, ready = 1, busy = 0;
  logic [23:0] status = 0;
  logic dout_intb, abort;
  logic [7:0] cfg, mux;
  logic [15:0] seq;
  logic [23:0] irq_en, coef;
  int tests = 0, fails = 0, abort_cnt = 0, hi_mis = 0;

  always #5 clk = ~clk;

  spi_regslave dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .din(din),
    .dout_intb(dout_intb), .ready(ready), .busy(busy), .abort(abort), .status(status),
    .cfg(cfg), .mux(mux), .seq(seq), .irq_en(irq_en), .coef(coef));

  always @(posedge clk) if (abort) abort_cnt <= abort_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] bits, input int n, output logic [31:0] got);
    got = '0;
    csb = 0;
    wait_n(HP);
    for (int i = 0; i < n; i++) begin
      din = bits[31-i];
      wait_n(HP);
      got[31-i] = dout_intb;
      sclk = 1;
      wait_n(HP/2);
      if (dout_intb !== got[31-i]) hi_mis++;
      wait_n(HP/2);
      sclk = 0;
    end
    wait_n(HP);
    csb = 1;
    wait_n(4*HP);
  endtask

  task automatic wr(input logic [6:0] a, input int w, input logic [23:0] d);
    logic [31:0] g;
    xfer({1'b0, a, d << (24-w)}, 8+w, g);
  endtask

  task automatic rd(input logic [6:0] a, input int w, output logic [23:0] d, output logic [7:0] h);
    logic [31:0] g;
    xfer({1'b1, a, 24'h0}, 8+w, g);
    d = g[23:0] >> (24-w);
    h = g[31:24];
  endtask

  task automatic t_reset;
    chk("R10 cfg", cfg, 0); chk("R10 seq", seq, 0); chk("R10 coef", coef, 0);
    chk("R10 abort", abort, 0); chk("R10 dout", dout_intb, 1);
  endtask

  task automatic t_widths;
    logic [23:0] d; logic [7:0] h;
    wr(7'h00, 8, 24'hA5);     chk("R3 cfg write", cfg, 8'hA5);
    wr(7'h01, 8, 24'h3C);     chk("R3 mux write", mux, 8'h3C);
    wr(7'h02, 16, 24'hBEEF);  chk("R3 seq write", seq, 16'hBEEF);
    wr(7'h05, 24, 24'h123456); chk("R3 coef write", coef, 24'h123456);
    hi_mis = 0;
    rd(7'h00, 8, d, h);  chk("R6 cfg read", d, 24'hA5); chk("R5 header flag", h, 8'hFF);
    rd(7'h02, 16, d, h); chk("R6 seq read", d, 24'hBEEF);
    rd(7'h05, 24, d, h); chk("R6 coef read", d, 24'h123456);
    chk("R1 dout stable in high phase", hi_mis, 0);
    chk("R6 read leaves coef", coef, 24'h123456);
  endtask

  task automatic t_unmapped;
    logic [23:0] d; logic [7:0] h;
    wr(7'h7F, 8, 24'h99);
    rd(7'h7F, 8, d, h); chk("R2 unmapped reads 0", d, 0);
    chk("R2 unmapped leaves cfg", cfg, 8'hA5);
  endtask

  task automatic t_irq;
    logic [23:0] d; logic [7:0] h;
    status = 24'h000100;
    wait_n(4); chk("R5 flag high when masked", dout_intb, 1);
    wr(7'h03, 24, 24'h000100);
    wait_n(4); chk("R5 flag low when enabled", dout_intb, 0);
    rd(7'h04, 24, d, h);
    chk("R2 status read", d, 24'h000100); chk("R5 header shows flag", h, 8'h00);
    rd(7'h03, 24, d, h); chk("R6 irq_en read", d, 24'h000100);
    wr(7'h03, 24, 24'h0);
    wait_n(4); chk("R5 flag cleared", dout_intb, 1);
    status = 0;
  endtask

  task automatic t_early;
    logic [31:0] g;
    int a0;
    busy = 1; a0 = abort_cnt;
    xfer({1'b0, 7'h05, 24'hFFFFFF}, 31, g);
    chk("R4 coef unchanged", coef, 24'h123456);
    chk("R4 no abort", abort_cnt, a0);
    xfer({1'b0, 7'h00, 8'h11, 16'h0}, 15, g);
    chk("R4 cfg unchanged", cfg, 8'hA5);
    busy = 0;
  endtask

  task automatic t_abort;
    logic [23:0] d; logic [7:0] h;
    int a0;
    busy = 1; a0 = abort_cnt;
    wr(7'h01, 8, 24'h77);
    chk("R7 abort once", abort_cnt, a0 + 1); chk("R7 write stored", mux, 8'h77);
    rd(7'h01, 8, d, h);
    chk("R6 read no abort", abort_cnt, a0 + 1);
    busy = 0;
    wr(7'h01, 8, 24'h78);
    chk("R7 no abort when idle", abort_cnt, a0 + 1);
  endtask

  task automatic t_ready;
    logic [23:0] d; logic [7:0] h;
    int a0;
    ready = 0; busy = 1; a0 = abort_cnt;
    wr(7'h00, 8, 24'h42);
    chk("R8 write ignored", cfg, 8'hA5); chk("R8 no abort", abort_cnt, a0);
    rd(7'h05, 24, d, h);
    chk("R8 read shows flag only", d, 24'hFFFFFF);
    ready = 1; busy = 0;
  endtask

  task automatic t_extra;
    logic [31:0] g;
    xfer({1'b0, 7'h00, 8'h5A, 16'hFFFF}, 32, g);
    chk("R9 extra clocks ignored", cfg, 8'h5A);
    xfer({1'b0, 7'h02, 16'h1234, 8'hFF}, 32, g);
    chk("R9 seq extra ignored", seq, 16'h1234);
  endtask

  initial begin
    wait_n(5); rst_n = 1; wait_n(5);
    t_reset; t_widths; t_unmapped; t_irq; t_early; t_abort; t_ready; t_extra;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule